// File: doc/BRIEF.md
# Byte-Multiplexed Converter Bus Interface

This block sits between an 8-bit microprocessor bus and the control side of a signed 13-bit converter core. It takes the four active-low bus strobes (chip select, read, write and a status-select line) and synchronises them to the system clock. Falling edges of read and write become bus events. From these it issues start and abort pulses to the core, latches each finished result and hands that result to the processor one byte at a time. The sign-extended upper byte comes first and the lower byte second.

An internal byte pointer picks which half the next data read returns. It flips on every data read and returns to the upper byte whenever a conversion completes. With status-select held low, a read returns a status byte and a write resets the interface. The status byte reports the busy state, the byte pointer, a result-latched flag and a data-ready flag. An active-low interrupt tells the processor that a fresh result is waiting. The processor can also pull read and write low together, which reads one byte and restarts the core in a single bus cycle.

Top module: `cvt_bus_if`

## Requirements
- R1: The upper byte of a result carries the sign bit (result bit 12) in bits 7:4 and result bits 11:8 in bits 3:0.
- R2: The lower byte of a result is result bits 7:0.
- R3: Each data read (chip select and read low, status-select high) flips the byte pointer exactly once, so successive reads alternate upper, lower, upper.
- R4: A completed conversion (end-of-conversion pulse) latches the result and forces the byte pointer back to the upper byte.
- R5: A status read (chip select, read and status-select low) returns a byte laid out as follows: bit 6 is busy, bit 2 is the byte pointer (1 means the next data read returns the lower byte), bit 1 is result-latched, bit 0 is data-ready, and bits 7, 5, 4 and 3 are zero.
- R6: Data-ready is set by end of conversion and cleared by a data read, a status read or a conversion start. Result-latched is set by end of conversion and cleared by a start or an abort.
- R7: The interrupt output goes low when a result is latched. It returns high on a data read or a start. A status read leaves it unchanged.
- R8: A status write (chip select, write and status-select low) gives one abort pulse and no start pulse. It clears both flags and the byte pointer, and it drives the interrupt high.
- R9: A write falling edge with chip select low and status-select high gives exactly one start pulse. When read and write are strobed low together, the bus returns the byte the pointer selects and a start is issued. A second combined strobe returns the other byte and restarts the core.
- R10: The data bus output enable is high only while chip select and read are both low. A read strobe with chip select high leaves the bus disabled and the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| stat_ni | input | 1 | Status-select, active low |
| res_i | input | 13 | Two's-complement result from the core |
| busy_i | input | 1 | Core conversion in progress |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse from the core |
| data_o | output | 8 | Bus byte (data or status) |
| data_oe_o | output | 1 | Bus output enable |
| irq_no | output | 1 | Interrupt, active low |
| start_o | output | 1 | One-cycle start request to the core |
| abort_o | output | 1 | One-cycle abort request to the core |

## Verification
The hardest states to reach from the ports are the combined read-write strobe and the byte pointer left on the lower byte when a new result arrives. In both, a read's side effect overlaps another event. The stimulus reaches these states by reading only the upper byte and then pulsing end-of-conversion. It also pulls read and write low together twice inside one conversion and checks both returned bytes and the count of start pulses. An abort issued while the pointer is on the lower byte is then confirmed through a status read.

// File: rtl/cvt_bus_pkg.sv
package cvt_bus_pkg;
  localparam int RES_W = 13;
  localparam int BUS_W = 8;

  // status byte bit positions (software decodes these)
  localparam int ST_BUSY = 6;
  localparam int ST_SEL  = 2;
  localparam int ST_EOC  = 1;
  localparam int ST_RDY  = 0;

  // strobe indices in the synchroniser bus
  localparam int IDX_CS = 0;
  localparam int IDX_RD = 1;
  localparam int IDX_WR = 2;
  localparam int IDX_ST = 3;
  localparam int N_STB  = 4;

  typedef struct packed {
    logic data_rd;
    logic stat_rd;
    logic start;
    logic abort;
  } bus_ev_t;
endpackage

// File: rtl/cvt_strobe_sync.sv
module cvt_strobe_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '1;
      else if (s == 0) chain[s] <= raw_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else prev_q <= chain[STAGES-1];
  end

  assign lvl_o  = chain[STAGES-1];
  assign fall_o = prev_q & ~chain[STAGES-1];
  assign rise_o = ~prev_q & chain[STAGES-1];
endmodule

// File: rtl/cvt_byte_steer.sv
module cvt_byte_steer
  import cvt_bus_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int BW = BUS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] res_i,
  input  logic          eoc_i,
  input  logic          rd_ev_i,
  input  logic          clr_i,
  output logic          sel_o,
  output logic [BW-1:0] byte_o
);
  localparam int EXT = 2*BW - RW + 1;

  logic [RW-1:0] res_q;
  logic          sel_q;
  logic [BW-1:0] hi_byte, lo_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      sel_q <= 1'b0;
    end else if (clr_i) begin
      res_q <= '0;
      sel_q <= 1'b0;
    end else begin
      if (eoc_i) res_q <= res_i;
      if (eoc_i) sel_q <= 1'b0;
      else if (rd_ev_i) sel_q <= ~sel_q;
    end
  end

  assign hi_byte = {{EXT{res_q[RW-1]}}, res_q[RW-2:BW]};
  assign lo_byte = res_q[BW-1:0];
  assign byte_o  = sel_q ? lo_byte : hi_byte;
  assign sel_o   = sel_q;

  a_r3_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ev_i && !eoc_i && !clr_i |=> sel_q != $past(sel_q));
  a_r4_eoc_to_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> !sel_q);
endmodule

// File: rtl/cvt_flag_ctrl.sv
module cvt_flag_ctrl
  import cvt_bus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    eoc_i,
  input  bus_ev_t ev_i,
  output logic    irq_no,
  output logic    eoc_flag_o,
  output logic    rdy_flag_o
);
  logic irq_q, eocf_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b1;
      eocf_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else if (ev_i.abort) begin
      irq_q  <= 1'b1;
      eocf_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      if (eoc_i) begin
        irq_q  <= 1'b0;
        eocf_q <= 1'b1;
        rdy_q  <= 1'b1;
      end
      // clearing events take precedence over a coincident completion
      if (ev_i.start) begin
        irq_q  <= 1'b1;
        eocf_q <= 1'b0;
        rdy_q  <= 1'b0;
      end
      if (ev_i.data_rd) begin
        irq_q <= 1'b1;
        rdy_q <= 1'b0;
      end
      if (ev_i.stat_rd) rdy_q <= 1'b0;
    end
  end

  assign irq_no     = irq_q;
  assign eoc_flag_o = eocf_q;
  assign rdy_flag_o = rdy_q;

  a_r7_irq_implies_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> eoc_flag_o);
  a_r6_ready_needs_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_flag_o |-> eoc_flag_o);
  a_r7_status_read_keeps_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.stat_rd && !ev_i.data_rd && !ev_i.start && !ev_i.abort && !eoc_i |=> $stable(irq_no));
endmodule

// File: rtl/cvt_bus_if.sv
module cvt_bus_if
  import cvt_bus_pkg::*;
#(
  parameter int RW          = RES_W,
  parameter int BW          = BUS_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          stat_ni,
  input  logic [RW-1:0] res_i,
  input  logic          busy_i,
  input  logic          eoc_i,
  output logic [BW-1:0] data_o,
  output logic          data_oe_o,
  output logic          irq_no,
  output logic          start_o,
  output logic          abort_o
);
  logic [N_STB-1:0] raw, lvl, fall, rise;
  bus_ev_t          ev;
  logic             sel;
  logic [BW-1:0]    cur_byte, stat_byte;
  logic             eoc_flag, rdy_flag;
  logic             cs_act, st_act;
  logic [BW-1:0]    data_q;
  logic             oe_q;

  assign raw[IDX_CS] = cs_ni;
  assign raw[IDX_RD] = rd_ni;
  assign raw[IDX_WR] = wr_ni;
  assign raw[IDX_ST] = stat_ni;

  cvt_strobe_sync #(.N(N_STB), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (raw),
    .lvl_o (lvl),
    .fall_o(fall),
    .rise_o(rise)
  );

  assign cs_act     = ~lvl[IDX_CS];
  assign st_act     = ~lvl[IDX_ST];
  assign ev.data_rd = fall[IDX_RD] & cs_act & ~st_act;
  assign ev.stat_rd = fall[IDX_RD] & cs_act &  st_act;
  assign ev.start   = fall[IDX_WR] & cs_act & ~st_act;
  assign ev.abort   = fall[IDX_WR] & cs_act &  st_act;

  cvt_byte_steer #(.RW(RW), .BW(BW)) u_steer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .res_i  (res_i),
    .eoc_i  (eoc_i),
    .rd_ev_i(ev.data_rd),
    .clr_i  (ev.abort),
    .sel_o  (sel),
    .byte_o (cur_byte)
  );

  cvt_flag_ctrl u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eoc_i     (eoc_i),
    .ev_i      (ev),
    .irq_no    (irq_no),
    .eoc_flag_o(eoc_flag),
    .rdy_flag_o(rdy_flag)
  );

  always_comb begin
    stat_byte          = '0;
    stat_byte[ST_BUSY] = busy_i;
    stat_byte[ST_SEL]  = sel;
    stat_byte[ST_EOC]  = eoc_flag;
    stat_byte[ST_RDY]  = rdy_flag;
  end

  // byte captured at the read edge, before the pointer and flags move
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= cs_act & ~lvl[IDX_RD];
      if (ev.data_rd) data_q <= cur_byte;
      else if (ev.stat_rd) data_q <= stat_byte;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;
  assign start_o   = ev.start;
  assign abort_o   = ev.abort;

  a_r8_start_abort_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && abort_o));
  a_r9_single_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r8_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> irq_no && !eoc_flag && !rdy_flag && !sel);
  a_r10_oe_drops_on_rd_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[IDX_RD] |=> !data_oe_o);
endmodule

// File: tb/cvt_bus_if_test.sv
module cvt_bus_if_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, st_n = 1'b1;
  logic [12:0] res = '0;
  logic        busy = 1'b0, eoc = 1'b0;
  logic [7:0]  data;
  logic        oe, irq_n, start, abort;

  int nchk = 0, nerr = 0;
  int n_start = 0, n_abort = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvt_bus_if uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .stat_ni(st_n), .res_i(res), .busy_i(busy), .eoc_i(eoc),
    .data_o(data), .data_oe_o(oe), .irq_no(irq_n), .start_o(start), .abort_o(abort)
  );

  always @(posedge clk) begin
    if (start) n_start++;
    if (abort) n_abort++;
  end

  // {result, upper byte, lower byte}
  localparam logic [28:0] VEC [0:5] = '{
    {13'h0000, 8'h00, 8'h00},
    {13'h0FFF, 8'h0F, 8'hFF},
    {13'h1000, 8'hF0, 8'h00},
    {13'h1FFF, 8'hFF, 8'hFF},
    {13'h0A5C, 8'h0A, 8'h5C},
    {13'h1234, 8'hF2, 8'h34}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert(input logic [12:0] v);
    @(negedge clk);
    res = v; eoc = 1'b1;
    @(negedge clk);
    eoc = 1'b0;
    idle(2);
  endtask

  task automatic bus_rd(input logic stat, output logic [7:0] b, output logic e);
    @(negedge clk);
    cs_n = 1'b0; st_n = stat; rd_n = 1'b0;
    idle(5);
    b = data; e = oe;
    rd_n = 1'b1; cs_n = 1'b1; st_n = 1'b1;
    idle(5);
  endtask

  task automatic bus_wr(input logic stat);
    @(negedge clk);
    cs_n = 1'b0; st_n = stat; wr_n = 1'b0;
    idle(5);
    wr_n = 1'b1; cs_n = 1'b1; st_n = 1'b1;
    idle(5);
  endtask

  task automatic bus_both(output logic [7:0] b);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    idle(5);
    b = data;
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    idle(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic e;
    int s0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    chk("reset oe", {7'd0, oe}, 8'h00);
    chk("reset irq", {7'd0, irq_n}, 8'h01);
    chk("reset start/abort", {6'd0, start, abort}, 8'h00);

    // table walk: R1, R2, R3, R7
    for (int i = 0; i < 6; i++) begin
      convert(VEC[i][28:16]);
      chk("R7 irq low after eoc", {7'd0, irq_n}, 8'h00);
      bus_rd(1'b1, b, e);
      chk("R1 upper byte", b, VEC[i][15:8]);
      chk("R10 oe during read", {7'd0, e}, 8'h01);
      chk("R7 irq high after read", {7'd0, irq_n}, 8'h01);
      bus_rd(1'b1, b, e);
      chk("R2 lower byte", b, VEC[i][7:0]);
      bus_rd(1'b1, b, e);
      chk("R3 third read upper", b, VEC[i][15:8]);
    end
    chk("R10 oe off after read", {7'd0, oe}, 8'h00);

    // R4: pointer left on lower byte, new result returns upper first
    convert(13'h0123);
    bus_rd(1'b1, b, e);
    convert(13'h1ABC);
    bus_rd(1'b1, b, e);
    chk("R4 upper after eoc", b, 8'hFA);

    // R5, R6: status contents and clearing by status read
    convert(13'h0055);
    busy = 1'b1;
    bus_rd(1'b0, b, e);
    chk("R5 status busy/eoc/rdy", b, 8'h43);
    busy = 1'b0;
    chk("R7 status read keeps irq", {7'd0, irq_n}, 8'h00);
    bus_rd(1'b0, b, e);
    chk("R6 status read clears rdy", b, 8'h02);

    // R6: data read clears rdy, pointer shows lower next
    convert(13'h0055);
    bus_rd(1'b1, b, e);
    bus_rd(1'b0, b, e);
    chk("R6 data read clears rdy R5 sel", b, 8'h06);

    // R6, R9: start clears flags, one start pulse
    convert(13'h0055);
    s0 = n_start;
    bus_wr(1'b1);
    chk("R9 one start pulse", 8'(n_start - s0), 8'h01);
    chk("R7 irq high after start", {7'd0, irq_n}, 8'h01);
    bus_rd(1'b0, b, e);
    chk("R6 start clears flags", b, 8'h00);

    // R8: abort
    convert(13'h0777);
    bus_rd(1'b1, b, e);
    s0 = n_start;
    bus_wr(1'b0);
    chk("R8 one abort pulse", 8'(n_abort), 8'h01);
    chk("R8 no start on abort", 8'(n_start - s0), 8'h00);
    chk("R8 irq high", {7'd0, irq_n}, 8'h01);
    bus_rd(1'b0, b, e);
    chk("R8 status cleared", b, 8'h00);

    // R9: combined strobes
    convert(13'h19E1);
    s0 = n_start;
    bus_both(b);
    chk("R9 combined upper", b, 8'hF9);
    bus_both(b);
    chk("R9 combined lower", b, 8'hE1);
    chk("R9 two starts", 8'(n_start - s0), 8'h02);

    // R10: read without chip select
    convert(13'h0C3D);
    @(negedge clk);
    rd_n = 1'b0;
    idle(5);
    chk("R10 oe off without cs", {7'd0, oe}, 8'h00);
    rd_n = 1'b1;
    idle(5);
    bus_rd(1'b1, b, e);
    chk("R10 pointer unchanged", b, 8'h0C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule